// File: doc/BRIEF.md
# USB Device IN-Endpoint Interrupt Status Unit

This unit gathers interrupt causes for the device side of a USB controller and presents them to the CPU as an 8-bit flag register and an 8-bit enable register on a single-cycle register bus. It watches two IN endpoints, called slot 0 (endpoint 0) and slot 1 (endpoint 3). For each slot it raises a "host asked but nothing to send" flag and a "packet delivered and acknowledged" flag. It also drives a per-slot NACK-select line that the packet engine uses to answer IN tokens.

A third source is the bus-power pin. It is brought into the clock domain through a two-flop synchronizer and then edge-detected. Both a connect edge and a disconnect edge raise a power-change flag. The synchronised pin level can also be read back as a status bit.

Software clears a flag by writing 0 to its bit and 1 to every other bit. A single registered interrupt line is high whenever any flag is set together with its enable bit.

Top module: `usbf_irq_flags`

## Requirements
- R1: After reset, both registers read 0x00 while the power pin is low, `irq` is 0, and `ep_nack` is 2'b11 while no FIFO holds data.
- R2: Flag register (address 0) layout: bit 0 is slot-0 request, bit 1 is slot-0 done, bit 2 is slot-1 request, bit 3 is slot-1 done, bit 4 is power change, and bit 5 is the power level. Bits 7:6 always read 0, and writing 1 to them has no effect.
- R3: A slot's request flag sets at the clock edge where `ep_in_token` is high while `ep_fifo_valid` for that slot is low. A token seen while the FIFO holds data leaves the flag at 0.
- R4: `ep_nack[i]` is 1 whenever `ep_fifo_valid[i]` is 0 or `ep_tx_en[i]` is 0. It is 0 only when both are 1.
- R5: A slot's done flag sets at the clock edge where `ep_ack` for that slot is high.
- R6: A write to address 0 clears each flag whose write-data bit is 0 and leaves each flag whose write-data bit is 1 unchanged.
- R7: When a set event and a clearing write reach the same flag in the same cycle, the flag ends set.
- R8: The level bit (bit 5) follows `vbus_pin` two clock edges after the pin changes, and writes to bit 5 have no effect.
- R9: The power-change flag (bit 4) sets one edge after the level bit changes, on rising and falling pin edges alike.
- R10: Enable register (address 1): bits 4:0 are read/write and gate flag bits 4:0 one for one. Bits 7:5 read 0.
- R11: `irq` is 1 in the cycle after the edge at which any flag and its enable bit are both 1. It returns to 0 one edge after the last such pair is broken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ep_in_token | input | 2 | IN token received, per slot |
| ep_fifo_valid | input | 2 | FIFO holds valid transmit data, per slot |
| ep_tx_en | input | 2 | Packet transmission enabled, per slot |
| ep_ack | input | 2 | Host ACK after transmit, per slot |
| ep_nack | output | 2 | Answer IN tokens with NACK, per slot |
| vbus_pin | input | 1 | Asynchronous bus-power pin |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
The embedded assertions check on every cycle that set events always land in the flag register, even against a clearing write. They also check that flags persist unless explicitly cleared, that the interrupt tracks the enabled flags with one cycle of latency, and that a request event is always accompanied by NACK. The register layout, the exact synchronizer delay on the power pin, the ignoring of writes to read-only and reserved bits, and the full matrix of endpoint input combinations, clear masks and enable masks are shown only by the bench's scenarios.

// File: rtl/usbf_irq_pkg.sv
// Package: shared constants for the USB interrupt status unit.
// Assumes two IN slots and one power-change source feeding the flag vector.
package usbf_irq_pkg;
    localparam int NUM_SLOT  = 2;
    localparam int DATA_W    = 8;
    localparam int FLAG_W    = 2 * NUM_SLOT + 1;
    localparam int PWR_BIT   = FLAG_W - 1;
    localparam logic ADDR_FLAGS  = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/usbf_vbus_sense.sv
// Module: synchronises the asynchronous power pin and flags any level change.
// Assumes SYNC_STAGES >= 2; the change output compares the synchronised
// sample against the previous synchronised sample.
module usbf_vbus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic change
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Hold the last synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign level  = sync_q[SYNC_STAGES-1];
    assign change = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/usbf_ep_events.sv
// Module: decodes per-slot packet-engine strobes into flag set events and
// a NACK-select level. Purely combinational; assumes strobes are one-cycle.
module usbf_ep_events #(
    parameter int NUM_SLOT = 2
) (
    input  logic [NUM_SLOT-1:0] in_token,
    input  logic [NUM_SLOT-1:0] fifo_valid,
    input  logic [NUM_SLOT-1:0] tx_en,
    input  logic [NUM_SLOT-1:0] ack,
    output logic [NUM_SLOT-1:0] req_set,
    output logic [NUM_SLOT-1:0] done_set,
    output logic [NUM_SLOT-1:0] nack
);
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        // Request event: token seen with nothing queued.
        assign req_set[s]  = in_token[s] & ~fifo_valid[s];
        // Done event: host acknowledged the delivered packet.
        assign done_set[s] = ack[s];
        // NACK until data is present and transmission is armed.
        assign nack[s]     = ~(fifo_valid[s] & tx_en[s]);
    end
endmodule

// File: rtl/usbf_irq_flags.sv
// Module: top of the interrupt status unit. Holds the flag and enable
// registers, the register bus decode and the registered interrupt output.
// Assumes a single-cycle register bus; set events win over clearing writes.
module usbf_irq_flags
    import usbf_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_SLOT-1:0] ep_in_token,
    input  logic [NUM_SLOT-1:0] ep_fifo_valid,
    input  logic [NUM_SLOT-1:0] ep_tx_en,
    input  logic [NUM_SLOT-1:0] ep_ack,
    output logic [NUM_SLOT-1:0] ep_nack,
    input  logic                vbus_pin,
    output logic                irq
);
    localparam int PAD_FLAG = DATA_W - FLAG_W - 1;
    localparam int PAD_EN   = DATA_W - FLAG_W;

    logic [NUM_SLOT-1:0] req_set, done_set;
    logic                pwr_level, pwr_change;
    logic [FLAG_W-1:0]   set_vec;
    logic [FLAG_W-1:0]   flag_q, en_q;
    logic                irq_q;
    logic                wr_flags, wr_enable;

    usbf_ep_events #(.NUM_SLOT(NUM_SLOT)) u_events (
        .in_token  (ep_in_token),
        .fifo_valid(ep_fifo_valid),
        .tx_en     (ep_tx_en),
        .ack       (ep_ack),
        .req_set   (req_set),
        .done_set  (done_set),
        .nack      (ep_nack)
    );

    usbf_vbus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_vbus (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (vbus_pin),
        .level (pwr_level),
        .change(pwr_change)
    );

    // Interleave per-slot events into the flag bit order.
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_setmap
        assign set_vec[2*s]   = req_set[s];
        assign set_vec[2*s+1] = done_set[s];
    end
    assign set_vec[PWR_BIT] = pwr_change;

    assign wr_flags  = reg_wr && (reg_addr == ADDR_FLAGS);
    assign wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);

    // Flag register: write-0-to-clear, set events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= '0;
        else if (wr_flags) flag_q <= (flag_q & reg_wdata[FLAG_W-1:0]) | set_vec;
        else               flag_q <= flag_q | set_vec;
    end

    // Enable register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_enable) en_q <= reg_wdata[FLAG_W-1:0];
    end

    // Registered interrupt request from enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & en_q);
    end

    // Read mux; reserved bits return zero.
    always_comb begin
        if (reg_addr == ADDR_FLAGS) reg_rdata = {{PAD_FLAG{1'b0}}, pwr_level, flag_q};
        else                        reg_rdata = {{PAD_EN{1'b0}}, en_q};
    end

    assign irq = irq_q;

    // Every set event is visible in the flag register after the edge.
    for (genvar b = 0; b < FLAG_W; b++) begin : g_chk
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[b] |=> flag_q[b]);
        // A set flag survives unless a clearing write hits it.
        assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[b] && !(wr_flags && !reg_wdata[b])) |=> flag_q[b]);
        // A clearing write with no set event drops the flag.
        assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flags && !reg_wdata[b] && !set_vec[b]) |=> !flag_q[b]);
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_nchk
        // A request event always coincides with NACK for that slot.
        assert_req_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
            req_set[s] |-> ep_nack[s]);
    end

    // Interrupt follows enabled flags with one cycle of latency.
    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & en_q)) |=> irq);
    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_q & en_q)) |=> !irq);
    // Power change always raises the power flag.
    assert_pwr_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_change |=> flag_q[PWR_BIT]);
endmodule

// File: tb/sim_usbf_irq_flags.sv
module sim_usbf_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] ep_in_token = '0, ep_fifo_valid = '0, ep_tx_en = '0, ep_ack = '0;
    logic [1:0] ep_nack;
    logic       vbus_pin = 1'b0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    usbf_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ep_in_token(ep_in_token), .ep_fifo_valid(ep_fifo_valid),
        .ep_tx_en(ep_tx_en), .ep_ack(ep_ack), .ep_nack(ep_nack),
        .vbus_pin(vbus_pin), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic read(input logic a, output logic [7:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    // Raise all four slot flags in one cycle.
    task automatic set_all_slots();
        ep_fifo_valid = 2'b00; ep_in_token = 2'b11; ep_ack = 2'b11;
        step();
        ep_in_token = 2'b00; ep_ack = 2'b00;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        read(0, rd); check("R1 flags", rd, 8'h00);
        read(1, rd); check("R1 enable", rd, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 nack", {6'd0, ep_nack}, 8'h03);

        // R3 R4 R5: every input combination on each slot
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 16; c++) begin
                logic tok, fv, te, ak;
                logic [7:0] exp;
                {tok, fv, te, ak} = c[3:0];
                write(0, 8'h00);
                ep_in_token[s] = tok; ep_fifo_valid[s] = fv;
                ep_tx_en[s] = te; ep_ack[s] = ak;
                #1 check("R4 nack", {7'd0, ep_nack[s]}, {7'd0, ~(fv & te)});
                step();
                ep_in_token = '0; ep_fifo_valid = '0; ep_tx_en = '0; ep_ack = '0;
                exp = 8'h00;
                exp[2*s]   = tok & ~fv;
                exp[2*s+1] = ak;
                read(0, rd);
                check("R3 R5 flags", rd, exp);
            end
        end

        // R6: every keep mask over the four slot flags
        for (int m = 0; m < 16; m++) begin
            set_all_slots();
            write(0, {4'h0, m[3:0]});
            read(0, rd);
            check("R6 clear mask", rd, {4'h0, m[3:0]});
        end

        // R7: set event and clearing write in the same cycle
        write(0, 8'h00);
        reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = 8'h00;
        ep_in_token = 2'b01; ep_ack = 2'b10;
        step();
        reg_wr = 1'b0; ep_in_token = '0; ep_ack = '0;
        read(0, rd); check("R7 set wins", rd, 8'h09);

        // R2: reserved and read-only bits ignore writes of 1
        write(0, 8'h00);
        write(0, 8'hFF);
        read(0, rd); check("R2 reserved", rd, 8'h00);

        // R10: enable register width
        write(1, 8'hFF);
        read(1, rd); check("R10 enable rw", rd, 8'h1F);

        // R11: every enable mask against all slot flags set
        set_all_slots();
        for (int e = 0; e < 32; e++) begin
            write(1, e[7:0]);
            step();
            check("R11 irq mask", {7'd0, irq}, {7'd0, |(e[3:0])});
        end
        write(1, 8'h0F);
        step();
        check("R11 irq on", {7'd0, irq}, 8'h01);
        write(0, 8'h00);
        check("R11 irq latency", {7'd0, irq}, 8'h01);
        step();
        check("R11 irq off", {7'd0, irq}, 8'h00);

        // R8 R9: power pin connect and disconnect
        write(1, 8'h10);
        vbus_pin = 1'b1;
        step();
        read(0, rd); check("R8 level after 1", rd, 8'h00);
        step();
        read(0, rd); check("R8 level after 2", rd, 8'h20);
        step();
        read(0, rd); check("R9 rise flag", rd, 8'h30);
        step();
        check("R11 pwr irq", {7'd0, irq}, 8'h01);
        write(0, 8'h00);
        read(0, rd); check("R8 level write ignored", rd, 8'h20);
        vbus_pin = 1'b0;
        step(); step();
        read(0, rd); check("R8 level low", rd, 8'h00);
        step();
        read(0, rd); check("R9 fall flag", rd, 8'h10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule